// File: doc/BRIEF.md
# Stack Machine Execute Datapath

This block is the execute half of a compact stack processor. The two topmost stack entries are held in registers: `tos` (top) and `nos` (next). Deeper entries sit in an internal stack RAM addressed by a stack pointer. Each cycle, an external decoder presents a set of registered control selects. The datapath then combines the two top registers in an adder/subtractor, a bitwise logic unit or a barrel shifter, or it takes a value from RAM, an immediate operand, an I/O input or a special register. Under those selects it also updates the top registers, the stack pointer and the RAM.

Besides the stack pointer, the block keeps a variable pointer and a program-counter shadow register. Both load from the top register under their own enables. All three can be read back into the top register through the special-register path. The zero and negative flags are derived from the top register and go to the branch logic.

The controls are plain per-cycle selects with no handshake. Every operation completes in the clock edge that follows its selects, so there is no back-pressure.

Top module: `stk_exec_path`

## Requirements
- R1: While `rst` is high at a rising edge, `tos`, `nos`, the variable pointer and the PC shadow clear to zero, and the stack pointer loads the parameter `SP_INIT` (default 16).
- R2: On a rising edge with `a_en` high, `tos` loads the logic-mux result when `a_from_lmux`=1 and the arithmetic result when `a_from_lmux`=0. With `a_en` low, `tos` holds its value.
- R3: The arithmetic result is `nos - tos` (modulo 2^W) when `op_add`=0, and `nos + tos` when `op_add`=1.
- R4: The logic result is selected by `logic_op`: 0 passes `nos`, 1 gives `tos & nos`, 2 gives `tos | nos`, 3 gives `tos ^ nos`.
- R5: The shifter shifts `nos` by the low log2(W) bits of `tos`. The `shift_op` codes are: 0 logical right, 1 left, 2 arithmetic right, 3 logical right.
- R6: The logic-mux `lmux_sel` codes are: 0 logic result, 1 shift result, 2 RAM read data, 3 immediate, 4 `io_rdata`, 5 special register. Codes 6 and 7 give the logic result.
- R7: On a rising edge with `b_en` high, `nos` loads RAM read data when `b_from_ram`=1 and `tos` when `b_from_ram`=0. With `b_en` low, `nos` holds its value.
- R8: When `ram_we` is high, a rising edge writes `nos` (`wdata_from_b`=1) or `tos` (`wdata_from_b`=0) to address `dir_addr` if `wr_dir`=1, and otherwise to address stack pointer + 1. The read data comes combinationally from `dir_addr` if `rd_dir`=1, and otherwise from the stack pointer.
- R9: At each rising edge, `sp_op` updates the stack pointer: 0 hold, 1 decrement, 2 increment, 3 load from the low ADDR_W bits of `tos`. The pointer wraps modulo 2^ADDR_W.
- R10: The special-register value is selected by `sreg_sel`: 0 the zero-extended stack pointer, 1 the variable pointer, 2 or 3 the PC shadow. The variable pointer loads `tos` when `vp_en` is high, and the PC shadow loads `tos` when `pcs_en` is high.
- R11: The immediate is formed from `opd` by `imm_mode`: 0 low byte zero-extended, 1 low byte sign-extended, 2 all 16 bits zero-extended, 3 all 16 bits sign-extended.
- R12: `zf` is 1 exactly when `tos` is zero, and `nf` equals the top bit of `tos`. Both follow `tos` combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| op_add | input | 1 | 1 selects add, 0 selects subtract |
| a_from_lmux | input | 1 | Source for top register: 1 logic mux, 0 arithmetic |
| a_en | input | 1 | Top register load enable |
| logic_op | input | 2 | Logic unit operation |
| shift_op | input | 2 | Shifter operation |
| lmux_sel | input | 3 | Logic-mux source select |
| imm_mode | input | 2 | Immediate formation mode |
| opd | input | OPD_W | Operand bytes for the immediate |
| io_rdata | input | W | I/O read value |
| sreg_sel | input | 2 | Special-register select |
| b_from_ram | input | 1 | Source for next register: 1 RAM, 0 top register |
| b_en | input | 1 | Next register load enable |
| wdata_from_b | input | 1 | RAM write data: 1 next register, 0 top register |
| ram_we | input | 1 | RAM write enable |
| rd_dir | input | 1 | RAM read address: 1 direct, 0 stack pointer |
| wr_dir | input | 1 | RAM write address: 1 direct, 0 stack pointer + 1 |
| dir_addr | input | ADDR_W | Direct RAM address |
| sp_op | input | 2 | Stack-pointer update code |
| vp_en | input | 1 | Variable pointer load enable |
| pcs_en | input | 1 | PC shadow load enable |
| tos | output | W | Top-of-stack register |
| nos | output | W | Next-on-stack register |
| zf | output | 1 | Zero flag of top register |
| nf | output | 1 | Negative flag of top register |

## Verification
The hardest state to reach from the ports is a RAM word at a known address, because that word can only be observed through a second operation that moves it into a top register. It is just as hard to reach a stack pointer at its wrap boundary, because the pointer is seen only by routing it through the special-register path into `tos`. The stimulus first places a chosen value in `tos` from the I/O input and loads it into the stack pointer. It then runs a push that writes `nos` above the pointer, followed by a pop that reads the same word back into `nos`. For wrap-around, it loads the pointer with the all-ones value and increments it. A separate round trip through a direct address checks the other RAM address path.

// File: rtl/stk_exec_pkg.sv
`timescale 1ns/1ps
package stk_exec_pkg;

  typedef enum logic [1:0] {
    LOG_PASS_B = 2'd0,
    LOG_AND    = 2'd1,
    LOG_OR     = 2'd2,
    LOG_XOR    = 2'd3
  } logic_op_e;

  typedef enum logic [1:0] {
    SH_LSR  = 2'd0,
    SH_LSL  = 2'd1,
    SH_ASR  = 2'd2,
    SH_LSR2 = 2'd3
  } shift_op_e;

  typedef enum logic [2:0] {
    LM_LOGIC = 3'd0,
    LM_SHIFT = 3'd1,
    LM_RAM   = 3'd2,
    LM_IMM   = 3'd3,
    LM_IO    = 3'd4,
    LM_SREG  = 3'd5,
    LM_RSV6  = 3'd6,
    LM_RSV7  = 3'd7
  } lmux_e;

  typedef enum logic [1:0] {
    SP_HOLD = 2'd0,
    SP_DEC  = 2'd1,
    SP_INC  = 2'd2,
    SP_LOAD = 2'd3
  } sp_op_e;

  typedef enum logic [1:0] {
    IMM_U8  = 2'd0,
    IMM_S8  = 2'd1,
    IMM_U16 = 2'd2,
    IMM_S16 = 2'd3
  } imm_mode_e;

endpackage

// File: rtl/stk_alu.sv
`timescale 1ns/1ps
module stk_alu #(
  parameter int W = 32
) (
  input  logic [W-1:0] top_v,
  input  logic [W-1:0] nxt_v,
  input  logic         op_add,
  input  logic [1:0]   logic_op,
  input  logic [1:0]   shift_op,
  output logic [W-1:0] arith_res,
  output logic [W-1:0] logic_res,
  output logic [W-1:0] shift_res
);
  import stk_exec_pkg::*;

  localparam int SHW = $clog2(W);

  // Adder/subtractor: the next entry is the left operand.
  assign arith_res = op_add ? (nxt_v + top_v) : (nxt_v - top_v);

  always_comb begin
    case (logic_op_e'(logic_op))
      LOG_AND: logic_res = top_v & nxt_v;
      LOG_OR:  logic_res = top_v | nxt_v;
      LOG_XOR: logic_res = top_v ^ nxt_v;
      default: logic_res = nxt_v;
    endcase
  end

  function automatic logic [W-1:0] flip(input logic [W-1:0] v);
    logic [W-1:0] r;
    for (int i = 0; i < W; i++) r[i] = v[W-1-i];
    return r;
  endfunction

  // Logarithmic barrel shifter: left shifts reuse the right-shift stages
  // on a bit-reversed word.
  logic           go_left;
  logic           fill;
  logic [SHW-1:0] amt;
  logic [W-1:0]   stg [SHW+1];

  assign go_left = (shift_op_e'(shift_op) == SH_LSL);
  assign fill    = (shift_op_e'(shift_op) == SH_ASR) & nxt_v[W-1];
  assign amt     = top_v[SHW-1:0];
  assign stg[0]  = go_left ? flip(nxt_v) : nxt_v;

  for (genvar k = 0; k < SHW; k++) begin : g_stage
    localparam int STEP = 1 << k;
    assign stg[k+1] = amt[k] ? {{STEP{fill}}, stg[k][W-1:STEP]} : stg[k];
  end

  assign shift_res = go_left ? flip(stg[SHW]) : stg[SHW];

endmodule

// File: rtl/stk_imm_fmt.sv
`timescale 1ns/1ps
module stk_imm_fmt #(
  parameter int W     = 32,
  parameter int OPD_W = 16
) (
  input  logic [OPD_W-1:0] opd,
  input  logic [1:0]       imm_mode,
  output logic [W-1:0]     imm
);
  import stk_exec_pkg::*;

  localparam int HALF = OPD_W / 2;

  always_comb begin
    case (imm_mode_e'(imm_mode))
      IMM_U8:  imm = {{(W-HALF){1'b0}}, opd[HALF-1:0]};
      IMM_S8:  imm = {{(W-HALF){opd[HALF-1]}}, opd[HALF-1:0]};
      IMM_U16: imm = {{(W-OPD_W){1'b0}}, opd};
      default: imm = {{(W-OPD_W){opd[OPD_W-1]}}, opd};
    endcase
  end

endmodule

// File: rtl/stk_ram.sv
`timescale 1ns/1ps
module stk_ram #(
  parameter int W      = 32,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [W-1:0]      wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [W-1:0]      rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];

endmodule

// File: rtl/stk_exec_path.sv
`timescale 1ns/1ps
module stk_exec_path #(
  parameter int W       = 32,
  parameter int ADDR_W  = 8,
  parameter int OPD_W   = 16,
  parameter int SP_INIT = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              op_add,
  input  logic              a_from_lmux,
  input  logic              a_en,
  input  logic [1:0]        logic_op,
  input  logic [1:0]        shift_op,
  input  logic [2:0]        lmux_sel,
  input  logic [1:0]        imm_mode,
  input  logic [OPD_W-1:0]  opd,
  input  logic [W-1:0]      io_rdata,
  input  logic [1:0]        sreg_sel,
  input  logic              b_from_ram,
  input  logic              b_en,
  input  logic              wdata_from_b,
  input  logic              ram_we,
  input  logic              rd_dir,
  input  logic              wr_dir,
  input  logic [ADDR_W-1:0] dir_addr,
  input  logic [1:0]        sp_op,
  input  logic              vp_en,
  input  logic              pcs_en,
  output logic [W-1:0]      tos,
  output logic [W-1:0]      nos,
  output logic              zf,
  output logic              nf
);
  import stk_exec_pkg::*;

  localparam int SHW = $clog2(W);
  localparam logic [ADDR_W-1:0] SP_RST = ADDR_W'(SP_INIT);
  localparam logic [ADDR_W-1:0] ONE_A  = ADDR_W'(1);

  logic [W-1:0]      a_q, b_q, vp_q, pcs_q;
  logic [ADDR_W-1:0] sp_q, sp_d;
  logic [W-1:0]      arith_res, logic_res, shift_res, imm_val;
  logic [W-1:0]      ram_rdata, ram_wdata, sreg_val, lmux_res, a_d, b_d;
  logic [ADDR_W-1:0] ram_raddr, ram_waddr;

  stk_alu #(.W(W)) u_alu (
    .top_v     (a_q),
    .nxt_v     (b_q),
    .op_add    (op_add),
    .logic_op  (logic_op),
    .shift_op  (shift_op),
    .arith_res (arith_res),
    .logic_res (logic_res),
    .shift_res (shift_res)
  );

  stk_imm_fmt #(.W(W), .OPD_W(OPD_W)) u_imm (
    .opd      (opd),
    .imm_mode (imm_mode),
    .imm      (imm_val)
  );

  assign ram_raddr = rd_dir ? dir_addr : sp_q;
  assign ram_waddr = wr_dir ? dir_addr : (sp_q + ONE_A);
  assign ram_wdata = wdata_from_b ? b_q : a_q;

  stk_ram #(.W(W), .ADDR_W(ADDR_W)) u_ram (
    .clk   (clk),
    .we    (ram_we),
    .waddr (ram_waddr),
    .wdata (ram_wdata),
    .raddr (ram_raddr),
    .rdata (ram_rdata)
  );

  always_comb begin
    case (sreg_sel)
      2'd0:    sreg_val = {{(W-ADDR_W){1'b0}}, sp_q};
      2'd1:    sreg_val = vp_q;
      default: sreg_val = pcs_q;
    endcase
  end

  always_comb begin
    case (lmux_e'(lmux_sel))
      LM_SHIFT: lmux_res = shift_res;
      LM_RAM:   lmux_res = ram_rdata;
      LM_IMM:   lmux_res = imm_val;
      LM_IO:    lmux_res = io_rdata;
      LM_SREG:  lmux_res = sreg_val;
      default:  lmux_res = logic_res;
    endcase
  end

  always_comb begin
    case (sp_op_e'(sp_op))
      SP_DEC:  sp_d = sp_q - ONE_A;
      SP_INC:  sp_d = sp_q + ONE_A;
      SP_LOAD: sp_d = a_q[ADDR_W-1:0];
      default: sp_d = sp_q;
    endcase
  end

  assign a_d = a_from_lmux ? lmux_res : arith_res;
  assign b_d = b_from_ram ? ram_rdata : a_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      a_q   <= '0;
      b_q   <= '0;
      vp_q  <= '0;
      pcs_q <= '0;
      sp_q  <= SP_RST;
    end else begin
      if (a_en)   a_q   <= a_d;
      if (b_en)   b_q   <= b_d;
      if (vp_en)  vp_q  <= a_q;
      if (pcs_en) pcs_q <= a_q;
      sp_q <= sp_d;
    end
  end

  assign tos = a_q;
  assign nos = b_q;
  assign zf  = (a_q == '0);
  assign nf  = a_q[W-1];

  // R2: top register holds without its enable
  a_r2_tos_hold: assert property (@(posedge clk) disable iff (rst)
    !a_en |=> $stable(tos));

  // R7: next register holds without its enable
  a_r7_nos_hold: assert property (@(posedge clk) disable iff (rst)
    !b_en |=> $stable(nos));

  // R3: subtraction result plus top operand recovers the next operand
  a_r3_sub_inverse: assert property (@(posedge clk) disable iff (rst)
    !op_add |-> (arith_res + tos) == nos);

  // R5: barrel left shift agrees with the shift operator
  a_r5_left_shift: assert property (@(posedge clk) disable iff (rst)
    (shift_op == 2'd1) |-> shift_res == (nos << tos[SHW-1:0]));

  // R5: code 3 behaves as a logical right shift
  a_r5_code3_lsr: assert property (@(posedge clk) disable iff (rst)
    (shift_op == 2'd3) |-> shift_res == (nos >> tos[SHW-1:0]));

  // R9: increment and decrement step by one with wrap
  a_r9_sp_inc: assert property (@(posedge clk) disable iff (rst)
    (sp_op == 2'd2) |=> sp_q == ($past(sp_q) + ONE_A));

  a_r9_sp_dec: assert property (@(posedge clk) disable iff (rst)
    (sp_op == 2'd1) |=> sp_q == ($past(sp_q) - ONE_A));

  // R9: load takes the low bits of the top register
  a_r9_sp_load: assert property (@(posedge clk) disable iff (rst)
    (sp_op == 2'd3) |=> sp_q == $past(tos[ADDR_W-1:0]));

  // R10: variable pointer and PC shadow hold without their enables
  a_r10_vp_hold: assert property (@(posedge clk) disable iff (rst)
    !vp_en |=> $stable(vp_q));

  a_r10_pcs_hold: assert property (@(posedge clk) disable iff (rst)
    !pcs_en |=> $stable(pcs_q));

endmodule

// File: tb/test_stk_exec_path.sv
`timescale 1ns/1ps
module test_stk_exec_path;

  localparam int W = 32;
  localparam int ADDR_W = 8;
  localparam int OPD_W = 16;
  localparam int SP_INIT = 16;

  logic clk = 1'b0;
  logic rst;
  logic op_add, a_from_lmux, a_en;
  logic [1:0] logic_op, shift_op, imm_mode, sreg_sel, sp_op;
  logic [2:0] lmux_sel;
  logic [OPD_W-1:0] opd;
  logic [W-1:0] io_rdata;
  logic b_from_ram, b_en, wdata_from_b, ram_we, rd_dir, wr_dir, vp_en, pcs_en;
  logic [ADDR_W-1:0] dir_addr;
  logic [W-1:0] tos, nos;
  logic zf, nf;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  stk_exec_path #(.W(W), .ADDR_W(ADDR_W), .OPD_W(OPD_W), .SP_INIT(SP_INIT)) i_stk_exec_path (
    .clk(clk), .rst(rst), .op_add(op_add), .a_from_lmux(a_from_lmux), .a_en(a_en),
    .logic_op(logic_op), .shift_op(shift_op), .lmux_sel(lmux_sel), .imm_mode(imm_mode),
    .opd(opd), .io_rdata(io_rdata), .sreg_sel(sreg_sel), .b_from_ram(b_from_ram),
    .b_en(b_en), .wdata_from_b(wdata_from_b), .ram_we(ram_we), .rd_dir(rd_dir),
    .wr_dir(wr_dir), .dir_addr(dir_addr), .sp_op(sp_op), .vp_en(vp_en), .pcs_en(pcs_en),
    .tos(tos), .nos(nos), .zf(zf), .nf(nf)
  );

  typedef struct packed {
    logic [31:0] a;
    logic [31:0] b;
    logic [2:0]  lm;
    logic [1:0]  lo;
    logic [1:0]  so;
    logic        al;
    logic        ad;
    logic [31:0] exp;
    logic [3:0]  req;
  } vec_t;

  // R3 arithmetic, R4 logic, R5 shift, R6 logic-mux codes
  localparam vec_t VEC [15] = '{
    '{32'h5,        32'h7,        3'd0, 2'd0, 2'd0, 1'b0, 1'b1, 32'd12,       4'd3},
    '{32'h5,        32'h7,        3'd0, 2'd0, 2'd0, 1'b0, 1'b0, 32'd2,        4'd3},
    '{32'h7,        32'h5,        3'd0, 2'd0, 2'd0, 1'b0, 1'b0, 32'hFFFFFFFE, 4'd3},
    '{32'h1,        32'hFFFFFFFF, 3'd0, 2'd0, 2'd0, 1'b0, 1'b1, 32'h0,        4'd3},
    '{32'hF0F0F0F0, 32'h12345678, 3'd0, 2'd0, 2'd0, 1'b1, 1'b0, 32'h12345678, 4'd4},
    '{32'hFF00FF00, 32'h12345678, 3'd0, 2'd1, 2'd0, 1'b1, 1'b0, 32'h12005600, 4'd4},
    '{32'hF0000000, 32'h0000000F, 3'd0, 2'd2, 2'd0, 1'b1, 1'b0, 32'hF000000F, 4'd4},
    '{32'hFFFFFFFF, 32'h12345678, 3'd0, 2'd3, 2'd0, 1'b1, 1'b0, 32'hEDCBA987, 4'd4},
    '{32'h4,        32'h80000010, 3'd1, 2'd0, 2'd0, 1'b1, 1'b0, 32'h08000001, 4'd5},
    '{32'h4,        32'h80000010, 3'd1, 2'd0, 2'd1, 1'b1, 1'b0, 32'h00000100, 4'd5},
    '{32'h4,        32'h80000010, 3'd1, 2'd0, 2'd2, 1'b1, 1'b0, 32'hF8000001, 4'd5},
    '{32'h4,        32'h80000010, 3'd1, 2'd0, 2'd3, 1'b1, 1'b0, 32'h08000001, 4'd5},
    '{32'h24,       32'h80000010, 3'd1, 2'd0, 2'd1, 1'b1, 1'b0, 32'h00000100, 4'd5},
    '{32'hFF00FF00, 32'h12345678, 3'd6, 2'd1, 2'd0, 1'b1, 1'b0, 32'h12005600, 4'd6},
    '{32'hFFFFFFFF, 32'h0,        3'd7, 2'd3, 2'd0, 1'b1, 1'b0, 32'hFFFFFFFF, 4'd6}
  };

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic clr();
    op_add = 0; a_from_lmux = 0; a_en = 0; logic_op = 0; shift_op = 0;
    lmux_sel = 0; imm_mode = 0; opd = 0; io_rdata = 0; sreg_sel = 0;
    b_from_ram = 0; b_en = 0; wdata_from_b = 0; ram_we = 0; rd_dir = 0;
    wr_dir = 0; dir_addr = 0; sp_op = 0; vp_en = 0; pcs_en = 0;
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic load_a(input logic [31:0] v);
    clr(); io_rdata = v; lmux_sel = 3'd4; a_from_lmux = 1; a_en = 1; tick();
  endtask

  task automatic set_ab(input logic [31:0] bv, input logic [31:0] av);
    load_a(bv);
    clr(); io_rdata = av; lmux_sel = 3'd4; a_from_lmux = 1; a_en = 1; b_en = 1; tick();
  endtask

  task automatic read_sreg(input logic [1:0] s);
    clr(); lmux_sel = 3'd5; sreg_sel = s; a_from_lmux = 1; a_en = 1; tick();
  endtask

  task automatic imm_check(input logic [1:0] m, input logic [31:0] exp);
    clr(); opd = 16'h8081; imm_mode = m; lmux_sel = 3'd3; a_from_lmux = 1; a_en = 1; tick();
    chk($sformatf("R11 imm mode %0d", m), tos, exp);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    clr();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state, R12 flags on zero
    chk("R1 tos after reset", tos, 32'h0);
    chk("R1 nos after reset", nos, 32'h0);
    chk("R12 zf on zero", {31'b0, zf}, 32'h1);
    chk("R12 nf on zero", {31'b0, nf}, 32'h0);
    read_sreg(2'd0);
    chk("R1 sp init", tos, 32'(SP_INIT));
    read_sreg(2'd1);
    chk("R1 vp cleared", tos, 32'h0);
    read_sreg(2'd2);
    chk("R1 pc shadow cleared", tos, 32'h0);

    // table walk
    for (int i = 0; i < 15; i++) begin
      set_ab(VEC[i].b, VEC[i].a);
      clr();
      lmux_sel = VEC[i].lm; logic_op = VEC[i].lo; shift_op = VEC[i].so;
      a_from_lmux = VEC[i].al; op_add = VEC[i].ad; a_en = 1;
      tick();
      chk($sformatf("R%0d vector %0d", VEC[i].req, i), tos, VEC[i].exp);
    end

    // R11 immediate modes
    imm_check(2'd0, 32'h00000081);
    imm_check(2'd1, 32'hFFFFFF81);
    imm_check(2'd2, 32'h00008081);
    imm_check(2'd3, 32'hFFFF8081);

    // R2 / R7 hold without enables
    set_ab(32'h11, 32'h77);
    clr(); io_rdata = 32'h99; lmux_sel = 3'd4; a_from_lmux = 1; tick();
    chk("R2 tos holds with a_en low", tos, 32'h77);
    chk("R7 nos holds with b_en low", nos, 32'h11);

    // R12 flags
    load_a(32'h80000000);
    chk("R12 nf set", {31'b0, nf}, 32'h1);
    chk("R12 zf clear", {31'b0, zf}, 32'h0);

    // R10 variable pointer and PC shadow
    load_a(32'h55);
    clr(); vp_en = 1; tick();
    load_a(32'h66);
    clr(); pcs_en = 1; tick();
    read_sreg(2'd1);
    chk("R10 vp read", tos, 32'h55);
    read_sreg(2'd2);
    chk("R10 pc shadow read", tos, 32'h66);
    read_sreg(2'd3);
    chk("R10 code 3 reads pc shadow", tos, 32'h66);

    // R9 stack pointer updates
    clr(); sp_op = 2'd2; tick();
    read_sreg(2'd0);
    chk("R9 sp increment", tos, 32'(SP_INIT + 1));
    load_a(32'h1FF);
    clr(); sp_op = 2'd3; tick();
    clr(); sp_op = 2'd2; tick();
    read_sreg(2'd0);
    chk("R9 sp wraps to zero", tos, 32'h0);
    clr(); sp_op = 2'd1; tick();
    read_sreg(2'd0);
    chk("R9 sp wraps down", tos, 32'hFF);

    // R8 / R7 RAM push and pop through the stack pointer
    load_a(32'h10);
    clr(); sp_op = 2'd3; tick();
    set_ab(32'hBBBB, 32'hAAAA);
    clr(); ram_we = 1; wdata_from_b = 1; sp_op = 2'd2; b_en = 1; tick();
    chk("R7 nos loads tos", nos, 32'hAAAA);
    clr(); b_en = 1; b_from_ram = 1; sp_op = 2'd1; tick();
    chk("R8 pop reads word above old sp", nos, 32'hBBBB);
    read_sreg(2'd0);
    chk("R9 sp back after pop", tos, 32'h10);

    // R8 direct address round trip with top register as data
    load_a(32'h12345678);
    clr(); ram_we = 1; wr_dir = 1; dir_addr = 8'h33; tick();
    load_a(32'h0);
    clr(); rd_dir = 1; dir_addr = 8'h33; lmux_sel = 3'd2; a_from_lmux = 1; a_en = 1; tick();
    chk("R8 direct write and read", tos, 32'h12345678);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

endmodule